// File: doc/BRIEF.md
# Palette DAC Host Interface

This block is the register-side front end of a colour look-up DAC. A host reaches it through a small port space: a write-index port that chooses a palette slot, a data port that takes the three colour components of that slot one write at a time, and a pixel-mask port. The block keeps a 256-entry palette of 6-bit red, green and blue values, the 8-bit pixel mask, and an 8-bit command byte. It decodes that command byte into a colour-mode output for the pixel path.

The command byte has no address of its own. It is reached through the mask port once an unlock sequence has been seen: a read of the index port, then four reads of the mask port in a row. After that, mask-port writes load the command byte instead of the mask, until the next index-port read restores normal behaviour. The palette contents are exposed on a read-only lookup port with one cycle of latency, so the pixel path, or a bench, can fetch any entry.

Port selection uses `acc_addr`: 0 is the index port, 1 is the data port, 2 is the mask port and 3 is a spare address that stores nothing and reads as zero. An access happens in a cycle where `acc_valid` is high. `acc_write` chooses between a write and a read. Read data on `acc_rdata` is combinational and belongs to the same cycle as the access.

Top module: `pal_dac_host`

## Requirements
- R1: A write to port 0 selects a palette slot. The following three writes to port 1 load red, then green, then blue from bits 5:0 of the write data, ignoring bits 7:6. Driving a slot number on `lut_addr` shows that slot on `lut_rgb` one cycle later, packed as red in [17:12], green in [11:6] and blue in [5:0].
- R2: After the blue write, the component sequence returns to red and the slot number increases by one, wrapping from 255 to 0. A read of port 0 returns the current slot number.
- R3: A write to port 0 in the middle of a colour restarts the sequence at red. The partly loaded components are dropped and no slot is written.
- R4: Out of reset, the pixel mask is 0xFF, the command byte is 0x00 and the slot number is 0. While the block is not unlocked, a write to port 2 loads the pixel mask, which shows on `pix_mask` and reads back from port 2.
- R5: A read of port 0 followed by exactly four consecutive reads of port 2 unlocks the command byte. From then on, port 2 writes load the command byte and leave the pixel mask unchanged, and the block stays unlocked across any number of such writes.
- R6: While the block is unlocked, port 2 reads return the command byte. A read of port 0 locks it again, so later port 2 writes go to the pixel mask.
- R7: During the unlock sequence, any access other than a port 2 read clears the read count. Port 2 reads that follow no port 0 read do not count. Cycles with `acc_valid` low do not break the sequence.
- R8: `color_mode` decodes the command byte: 0x00 gives 0 (256-colour), 0x10 gives 1 (15-bit), 0x30 gives 2 (16-bit), 0xD0 gives 3 (true colour), and any other value gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Port select: 0 index, 1 data, 2 mask, 3 spare |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the current access |
| lut_addr | input | 8 | Palette slot to look up |
| lut_rgb | output | 18 | Looked-up entry, one cycle after `lut_addr` |
| pix_mask | output | 8 | Current pixel mask |
| color_mode | output | 2 | Decoded colour mode |

## Verification
The palette loader is driven with a plain three-write colour, a run that continues through auto-increment, a load that crosses slot 255, and a colour broken off by a new index write. Together these separate correct sequencing from an index that fails to advance, fails to wrap, or keeps stale components. The unlock logic is driven with an exact unlock, a sequence cut by a foreign access, four mask reads with no leading index read, only three reads, and a sequence with idle gaps. Only the exact unlock and the gapped sequence may move the colour mode; every other case must land in the pixel mask. Each command value, plus one unrecognised value, is then checked against the mode output.

// File: rtl/pal_dac_pkg.sv
// Shared types for the palette DAC host interface.
// Assumes an 8-bit host bus and four port addresses.
package pal_dac_pkg;

    typedef enum logic [1:0] {
        PORT_INDEX = 2'd0,
        PORT_DATA  = 2'd1,
        PORT_MASK  = 2'd2,
        PORT_SPARE = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        MODE_PAL8   = 2'd0,
        MODE_RGB555 = 2'd1,
        MODE_RGB565 = 2'd2,
        MODE_RGB888 = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        SUB_RED   = 2'd0,
        SUB_GREEN = 2'd1,
        SUB_BLUE  = 2'd2
    } sub_e;

    typedef enum logic [1:0] {
        UNL_IDLE  = 2'd0,
        UNL_COUNT = 2'd1,
        UNL_ARMED = 2'd2
    } unl_e;

    // Map a command byte to a colour mode; unknown codes fall back to 8-bit palette.
    function automatic cmode_e decode_cmd(input logic [7:0] code);
        case (code)
            8'h00:   return MODE_PAL8;
            8'h10:   return MODE_RGB555;
            8'h30:   return MODE_RGB565;
            8'hD0:   return MODE_RGB888;
            default: return MODE_PAL8;
        endcase
    endfunction

endpackage

// File: rtl/pal_dac_unlock.sv
// Unlock tracker for the concealed command byte.
// Does: counts mask-port reads that follow an index-port read and
// raises 'armed' once UNLOCK_READS of them arrive back to back.
// Assumes: idx_rd and mask_rd are qualified by acc_valid; cycles with
// acc_valid low are not accesses and leave the count alone.
module pal_dac_unlock
    import pal_dac_pkg::*;
#(
    parameter int UNLOCK_READS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic idx_rd,
    input  logic mask_rd,
    output logic armed
);
    localparam int CNT_W = $clog2(UNLOCK_READS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_READS - 1);

    unl_e             st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state: index read (re)starts, mask reads count, anything else clears.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (acc_valid) begin
            if (idx_rd) begin
                st_d  = UNL_COUNT;
                cnt_d = '0;
            end else if (st_q == UNL_COUNT) begin
                if (mask_rd) begin
                    if (cnt_q == LAST) begin
                        st_d  = UNL_ARMED;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else begin
                    st_d  = UNL_IDLE;
                    cnt_d = '0;
                end
            end
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= UNL_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign armed = (st_q == UNL_ARMED);

    // R5: arming happens only on the last counted mask read.
    a_r5_arm_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == UNL_ARMED && $past(st_q) != UNL_ARMED)
            |-> ($past(mask_rd) && $past(cnt_q) == LAST));

    // R6: an index read always restarts from a zero count, disarmed.
    a_r6_index_read_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && idx_rd) |=> (st_q == UNL_COUNT && cnt_q == '0));

    // R7: a foreign access during counting drops back to idle.
    a_r7_foreign_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == UNL_COUNT && acc_valid && !mask_rd && !idx_rd) |=> (st_q == UNL_IDLE));

endmodule

// File: rtl/pal_dac_loader.sv
// Palette loader: slot pointer plus red/green/blue sub-component sequencer.
// Does: stages red and green, then issues one palette write on blue and
// advances the slot pointer (wrapping at the top).
// Assumes: idx_wr and data_wr never assert together (distinct port addresses).
module pal_dac_loader
    import pal_dac_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int COMP_W = 6,
    parameter int IDX_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idx_wr,
    input  logic                  data_wr,
    input  logic [BUS_W-1:0]      wdata,
    output logic [IDX_W-1:0]      wr_idx,
    output logic                  pal_we,
    output logic [3*COMP_W-1:0]   pal_din
);
    logic [COMP_W-1:0] red_q, grn_q, comp;
    logic [IDX_W-1:0]  idx_q;
    sub_e              sub_q;

    assign comp = wdata[COMP_W-1:0];

    // Pointer and component staging; index writes restart at red.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            sub_q <= SUB_RED;
            red_q <= '0;
            grn_q <= '0;
        end else if (idx_wr) begin
            idx_q <= wdata[IDX_W-1:0];
            sub_q <= SUB_RED;
        end else if (data_wr) begin
            case (sub_q)
                SUB_RED: begin
                    red_q <= comp;
                    sub_q <= SUB_GREEN;
                end
                SUB_GREEN: begin
                    grn_q <= comp;
                    sub_q <= SUB_BLUE;
                end
                default: begin
                    sub_q <= SUB_RED;
                    idx_q <= idx_q + 1'b1;
                end
            endcase
        end
    end

    assign wr_idx  = idx_q;
    assign pal_we  = data_wr && !idx_wr && (sub_q == SUB_BLUE);
    assign pal_din = {red_q, grn_q, comp};

    // R2: the blue write wraps the sequence and bumps the slot pointer.
    a_r2_blue_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !idx_wr && sub_q == SUB_BLUE)
            |=> (sub_q == SUB_RED && idx_q == IDX_W'($past(idx_q) + 1'b1)));

    // R3: an index write restarts at the red component.
    a_r3_index_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (sub_q == SUB_RED));

endmodule

// File: rtl/pal_dac_store.sv
// Palette storage: one write port, one registered read port.
// Assumes: a same-cycle read and write of one slot returns the old value.
module pal_dac_store #(
    parameter int COMP_W = 6,
    parameter int IDX_W  = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_W-1:0]    waddr,
    input  logic [3*COMP_W-1:0] din,
    input  logic [IDX_W-1:0]    raddr,
    output logic [3*COMP_W-1:0] dout
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int WORD  = 3 * COMP_W;

    logic [WORD-1:0] mem [DEPTH];

    // Write on strobe; register the lookup result.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= din;
        end
        dout <= mem[raddr];
    end

endmodule

// File: rtl/pal_dac_host.sv
// Palette DAC host interface (top).
// Does: decodes host accesses to the index, data and mask ports, keeps
// the pixel mask and the concealed command byte, and outputs the colour
// mode decoded from the command byte.
// Assumes: one access per cycle; read data is combinational.
module pal_dac_host
    import pal_dac_pkg::*;
#(
    parameter int          COMP_W       = 6,
    parameter int          IDX_W        = 8,
    parameter int          UNLOCK_READS = 4,
    parameter logic [7:0]  MASK_RESET   = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [1:0]            acc_addr,
    input  logic [7:0]            acc_wdata,
    output logic [7:0]            acc_rdata,
    input  logic [IDX_W-1:0]      lut_addr,
    output logic [3*COMP_W-1:0]   lut_rgb,
    output logic [7:0]            pix_mask,
    output logic [1:0]            color_mode
);
    localparam int BUS_W = 8;

    logic idx_rd, idx_wr, data_wr, mask_rd, mask_wr;
    logic armed;
    logic [IDX_W-1:0]    wr_idx;
    logic                pal_we;
    logic [3*COMP_W-1:0] pal_din;
    logic [BUS_W-1:0]    mask_q, cmd_q;

    // Port decode.
    always_comb begin
        idx_rd  = acc_valid && !acc_write && (acc_addr == PORT_INDEX);
        idx_wr  = acc_valid &&  acc_write && (acc_addr == PORT_INDEX);
        data_wr = acc_valid &&  acc_write && (acc_addr == PORT_DATA);
        mask_rd = acc_valid && !acc_write && (acc_addr == PORT_MASK);
        mask_wr = acc_valid &&  acc_write && (acc_addr == PORT_MASK);
    end

    pal_dac_unlock #(.UNLOCK_READS(UNLOCK_READS)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .idx_rd    (idx_rd),
        .mask_rd   (mask_rd),
        .armed     (armed)
    );

    pal_dac_loader #(.BUS_W(BUS_W), .COMP_W(COMP_W), .IDX_W(IDX_W)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .data_wr (data_wr),
        .wdata   (acc_wdata),
        .wr_idx  (wr_idx),
        .pal_we  (pal_we),
        .pal_din (pal_din)
    );

    pal_dac_store #(.COMP_W(COMP_W), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (pal_we),
        .waddr (wr_idx),
        .din   (pal_din),
        .raddr (lut_addr),
        .dout  (lut_rgb)
    );

    // Mask-port writes go to the command byte when armed, else the pixel mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RESET;
            cmd_q  <= '0;
        end else if (mask_wr) begin
            if (armed) cmd_q  <= acc_wdata;
            else       mask_q <= acc_wdata;
        end
    end

    // Read data mux for the current access.
    always_comb begin
        acc_rdata = '0;
        if (acc_valid && !acc_write) begin
            case (acc_addr)
                PORT_INDEX: acc_rdata = BUS_W'(wr_idx);
                PORT_MASK:  acc_rdata = armed ? cmd_q : mask_q;
                default:    acc_rdata = '0;
            endcase
        end
    end

    assign pix_mask   = mask_q;
    assign color_mode = decode_cmd(cmd_q);

    // R4: the pixel mask moves only on an unarmed mask write.
    a_r4_mask_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_q) |-> $past(mask_wr && !armed));

    // R5: an unarmed mask write leaves the command byte alone.
    a_r5_cmd_held_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !armed) |=> $stable(cmd_q));

    // R8: the colour mode changes only after an armed mask write.
    a_r8_mode_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(color_mode) |-> $past(mask_wr && armed));

endmodule

// File: tb/pal_dac_host_test.sv
module pal_dac_host_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_addr;
    logic [7:0]  acc_wdata, acc_rdata;
    logic [7:0]  lut_addr;
    logic [17:0] lut_rgb;
    logic [7:0]  pix_mask;
    logic [1:0]  color_mode;

    always #10 clk = ~clk;

    pal_dac_host uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .lut_addr(lut_addr), .lut_rgb(lut_rgb), .pix_mask(pix_mask),
        .color_mode(color_mode)
    );

    localparam int K_RD = 0, K_LUT = 1, K_MODE = 2, K_MASK = 3;

    typedef struct {
        int          kind;
        logic [17:0] exp;
        string       tag;
        int          due;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected items when due and compares against outputs.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [17:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = {10'd0, acc_rdata};
                K_LUT:   act = lut_rgb;
                K_MODE:  act = {16'd0, color_mode};
                default: act = {10'd0, pix_mask};
            endcase
            checks++;
            if (it.due < cyc) begin
                errors++;
                $display("FAIL %s: item missed its cycle (actual %h expected %h)", it.tag, act, it.exp);
            end else if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [17:0] exp, input string tag, input int due);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag; it.due = due;
        q.push_back(it);
    endtask

    // One access cycle followed by an idle cycle.
    task automatic acc(input logic wr, input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        @(posedge clk); #2;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Read access with an expected read value in the same cycle.
    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #2;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_wdata = 8'h00;
        push(K_RD, {10'd0, exp}, tag, cyc);
        @(posedge clk); #2;
        acc_valid = 1'b0;
    endtask

    task automatic lut_chk(input logic [7:0] a, input logic [17:0] exp, input string tag);
        @(posedge clk); #2;
        lut_addr = a;
        push(K_LUT, exp, tag, cyc + 1);
        @(posedge clk); #2;
    endtask

    task automatic state_chk(input logic [1:0] mode, input logic [7:0] mask, input string tag);
        push(K_MODE, {16'd0, mode}, tag, cyc);
        push(K_MASK, {10'd0, mask}, tag, cyc);
        @(posedge clk); #2;
    endtask

    task automatic rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        acc(1'b1, 2'd1, r); acc(1'b1, 2'd1, g); acc(1'b1, 2'd1, b);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = 2'd0;
        acc_wdata = 8'h00; lut_addr = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R4 reset state
        state_chk(2'd0, 8'hFF, "R4 reset mode/mask");
        rd_chk(2'd0, 8'h00, "R4 reset index");
        rd_chk(2'd2, 8'hFF, "R4 reset mask read");

        // R1 basic load, upper bits ignored
        acc(1'b1, 2'd0, 8'd5);
        rgb(8'h3A, 8'h15, 8'hFF);
        lut_chk(8'd5, {6'h3A, 6'h15, 6'h3F}, "R1 slot 5");

        // R2 auto increment and wrap
        rgb(8'h01, 8'h02, 8'h03);
        lut_chk(8'd6, {6'h01, 6'h02, 6'h03}, "R2 slot 6 after increment");
        rd_chk(2'd0, 8'd7, "R2 index after two colours");
        acc(1'b1, 2'd0, 8'd255);
        rgb(8'h0A, 8'h0B, 8'h0C);
        rd_chk(2'd0, 8'd0, "R2 index wraps to 0");
        lut_chk(8'd255, {6'h0A, 6'h0B, 6'h0C}, "R2 slot 255");
        lut_chk(8'd5, {6'h3A, 6'h15, 6'h3F}, "R1 slot 5 kept");

        // R3 index write restarts sequence
        acc(1'b1, 2'd0, 8'd20);
        acc(1'b1, 2'd1, 8'h11);
        acc(1'b1, 2'd0, 8'd20);
        rgb(8'h21, 8'h22, 8'h23);
        lut_chk(8'd20, {6'h21, 6'h22, 6'h23}, "R3 restart at red");
        rd_chk(2'd0, 8'd21, "R3 index after restart");

        // R4 normal mask write
        acc(1'b1, 2'd2, 8'h0F);
        rd_chk(2'd2, 8'h0F, "R4 mask readback");
        state_chk(2'd0, 8'h0F, "R4 mask write, mode unchanged");

        // R5 exact unlock
        rd_chk(2'd0, 8'd21, "R5 index read");
        for (int i = 0; i < 4; i++) rd_chk(2'd2, 8'h0F, "R5 counted mask read");
        acc(1'b1, 2'd2, 8'h30);
        state_chk(2'd2, 8'h0F, "R5 command write, mask kept");

        // R6 armed read returns command; index read relocks
        rd_chk(2'd2, 8'h30, "R6 armed read gives command");
        acc(1'b0, 2'd0, 8'h00);
        acc(1'b1, 2'd2, 8'h55);
        state_chk(2'd2, 8'h55, "R6 relocked write to mask");
        rd_chk(2'd2, 8'h55, "R6 relocked read gives mask");

        // R7 foreign access in the middle
        acc(1'b0, 2'd0, 8'h00);
        acc(1'b0, 2'd2, 8'h00); acc(1'b0, 2'd2, 8'h00);
        acc(1'b1, 2'd3, 8'hAA);
        acc(1'b0, 2'd2, 8'h00); acc(1'b0, 2'd2, 8'h00);
        acc(1'b1, 2'd2, 8'hD0);
        state_chk(2'd2, 8'hD0, "R7 interrupted sequence");
        rd_chk(2'd3, 8'h00, "R7 spare port reads zero");

        // R7 no leading index read
        for (int i = 0; i < 4; i++) acc(1'b0, 2'd2, 8'h00);
        acc(1'b1, 2'd2, 8'h77);
        state_chk(2'd2, 8'h77, "R7 no index read");

        // R7 only three reads
        acc(1'b0, 2'd0, 8'h00);
        for (int i = 0; i < 3; i++) acc(1'b0, 2'd2, 8'h00);
        acc(1'b1, 2'd2, 8'h88);
        state_chk(2'd2, 8'h88, "R7 three reads only");

        // R7 idle gaps keep the count
        acc(1'b0, 2'd0, 8'h00);
        acc(1'b0, 2'd2, 8'h00); acc(1'b0, 2'd2, 8'h00);
        repeat (3) @(posedge clk);
        #2;
        acc(1'b0, 2'd2, 8'h00); acc(1'b0, 2'd2, 8'h00);
        acc(1'b1, 2'd2, 8'h10);
        state_chk(2'd1, 8'h88, "R7 idle gap, R8 code 0x10");

        // R8 decode, still armed
        acc(1'b1, 2'd2, 8'hD0);
        state_chk(2'd3, 8'h88, "R8 code 0xD0");
        acc(1'b1, 2'd2, 8'h00);
        state_chk(2'd0, 8'h88, "R8 code 0x00");
        acc(1'b1, 2'd2, 8'h30);
        state_chk(2'd2, 8'h88, "R8 code 0x30");
        acc(1'b1, 2'd2, 8'h20);
        state_chk(2'd0, 8'h88, "R8 unknown code");
        acc(1'b1, 2'd2, 8'h30);

        // R6 final relock
        acc(1'b0, 2'd0, 8'h00);
        acc(1'b1, 2'd2, 8'hFF);
        state_chk(2'd2, 8'hFF, "R6 final relock");

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule